// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is one ALU lane for small-integer inference arithmetic. Each operation presents two 32-bit source words that hold packed integers, plus a 32-bit accumulator value. The lane splits both sources the same way, multiplies the matching lanes, reduces all the products to one sum, and adds that sum to the accumulator.

The lane split is chosen per operation. It is either four 8-bit lanes (a four-term dot product) or eight 4-bit lanes (an eight-term dot product). A per-operation flag chooses whether lanes are read as two's complement or as unsigned. A second flag chooses between a wrapping final add and a clamped final add.

Operations enter on `in_valid`, at a rate of up to one per clock. Each result appears with `out_valid` after a fixed two-cycle latency. There is no backpressure: the issue logic upstream owns scheduling.

Top module: `packed_dot_acc`

## Requirements
- R1: With `lane_mode`=0, each source holds four 8-bit lanes, lane i at bits [8i+7:8i]. The result is `acc_in` plus the sum of the four lane products.
- R2: With `lane_mode`=1, each source holds eight 4-bit lanes, lane i at bits [4i+3:4i]. The result is `acc_in` plus the sum of the eight lane products.
- R3: With `signed_en`=1, every lane of both sources is read as two's complement. With `signed_en`=0, every lane is read as unsigned (zero-extended).
- R4: With `sat_en`=0, the final 32-bit add of the lane sum to `acc_in` wraps modulo 2^32.
- R5: With `sat_en`=1, the final add is clamped to the signed 32-bit range [-2^31, 2^31-1]. `acc_in` is read as signed.
- R6: `out_valid` is high exactly two clock cycles after the cycle in which `in_valid` was sampled high. `result` carries that operation's value in the same cycle.
- R7: A new operation may be presented on every cycle. Back-to-back operations produce results in the cycles that follow, in order, each with its own mode and flags.
- R8: A synchronous active-high `rst` clears both pipeline valid bits, so `out_valid` is low after reset and any operation in flight is dropped.
- R9: The lane sum is exact for every operand value in every mode, including all-ones unsigned and most-negative signed lanes. Any wrap can happen only in the final 32-bit add.
- R10: When either source word is zero, the result equals `acc_in` whatever the mode and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| lane_mode | input | 1 | 0: four 8-bit lanes, 1: eight 4-bit lanes |
| signed_en | input | 1 | 1: lanes read as two's complement |
| sat_en | input | 1 | 1: clamp the final add to the signed 32-bit range |
| src_a | input | 32 | First packed source word |
| src_b | input | 32 | Second packed source word |
| acc_in | input | 32 | Accumulator value added to the lane sum |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Dot product plus accumulator |

## Verification
The assertions assume that `in_valid` and every operand and flag are at known values in every cycle after reset. They also assume that inputs can change freely from one cycle to the next, because the latency and zero-operand checks reach back two cycles to compare against past input values. The latency checks are enabled only once two clean cycles have passed since reset, so they never look back into a reset cycle. The bench keeps to these assumptions: it drives every input to a defined value on the falling edge at all times, holds `in_valid` low whenever an operation is not being issued, and releases reset only after all inputs are idle.

// File: rtl/pdot_pkg.sv
package pdot_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES_MAX  = 8;
    localparam int BYTE_LANES = 4;
    localparam int OPND_W     = 9;
    localparam int PROD_W     = 2 * OPND_W;
    localparam int SUM_W      = WORD_W + 2;

    typedef enum logic {
        SPLIT_BYTE   = 1'b0,
        SPLIT_NIBBLE = 1'b1
    } lane_split_e;

    typedef logic signed [OPND_W-1:0] opnd_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic                           valid;
        logic                           sat;
        logic [WORD_W-1:0]              acc;
        logic [LANES_MAX-1:0][PROD_W-1:0] prod;
    } stage1_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] value;
    } stage2_t;

    function automatic opnd_t widen_byte(input logic [7:0] raw, input logic sg);
        return sg ? opnd_t'({raw[7], raw}) : opnd_t'({1'b0, raw});
    endfunction

    function automatic opnd_t widen_nibble(input logic [3:0] raw, input logic sg);
        return sg ? opnd_t'({{5{raw[3]}}, raw}) : opnd_t'({5'b0, raw});
    endfunction

endpackage

// File: rtl/pdot_lane_split.sv
module pdot_lane_split
    import pdot_pkg::*;
#(
    parameter int LANES = LANES_MAX,
    parameter int BLANES = BYTE_LANES
) (
    input  logic [WORD_W-1:0]            word,
    input  lane_split_e                  split,
    input  logic                         sg,
    output logic [LANES-1:0][OPND_W-1:0] opnd
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < BLANES) begin : g_dual
            always_comb begin
                if (split == SPLIT_BYTE)
                    opnd[i] = widen_byte(word[8*i +: 8], sg);
                else
                    opnd[i] = widen_nibble(word[4*i +: 4], sg);
            end
        end else begin : g_nib_only
            always_comb begin
                if (split == SPLIT_BYTE)
                    opnd[i] = '0;
                else
                    opnd[i] = widen_nibble(word[4*i +: 4], sg);
            end
        end
    end

endmodule

// File: rtl/pdot_lane_mul.sv
module pdot_lane_mul
    import pdot_pkg::*;
(
    input  logic [OPND_W-1:0] a,
    input  logic [OPND_W-1:0] b,
    output logic [PROD_W-1:0] p
);

    opnd_t sa;
    opnd_t sb;
    prod_t sp;

    always_comb begin
        sa = opnd_t'(a);
        sb = opnd_t'(b);
        sp = sa * sb;
        p  = sp;
    end

endmodule

// File: rtl/pdot_reduce.sv
module pdot_reduce
    import pdot_pkg::*;
#(
    parameter int LANES = LANES_MAX
) (
    input  logic [LANES-1:0][PROD_W-1:0] prod,
    input  logic [WORD_W-1:0]            acc,
    input  logic                         sat,
    output logic [WORD_W-1:0]            value
);

    localparam logic signed [SUM_W-1:0] POS_LIMIT = SUM_W'((64'sd1 <<< (WORD_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] NEG_LIMIT = -SUM_W'(64'sd1 <<< (WORD_W-1));

    logic signed [SUM_W-1:0] lane_sum;
    logic signed [SUM_W-1:0] total;

    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_sum = lane_sum + SUM_W'(prod_t'(prod[i]));
        end
        total = lane_sum + {{(SUM_W-WORD_W){acc[WORD_W-1]}}, acc};
        if (!sat)
            value = total[WORD_W-1:0];
        else if (total > POS_LIMIT)
            value = POS_LIMIT[WORD_W-1:0];
        else if (total < NEG_LIMIT)
            value = NEG_LIMIT[WORD_W-1:0];
        else
            value = total[WORD_W-1:0];
    end

endmodule

// File: rtl/packed_dot_acc.sv
module packed_dot_acc
    import pdot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        lane_mode,
    input  logic        signed_en,
    input  logic        sat_en,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [31:0] acc_in,
    output logic        out_valid,
    output logic [31:0] result
);

    lane_split_e                      split;
    logic [LANES_MAX-1:0][OPND_W-1:0] opnd_a;
    logic [LANES_MAX-1:0][OPND_W-1:0] opnd_b;
    logic [LANES_MAX-1:0][PROD_W-1:0] prod_c;
    logic [WORD_W-1:0]                reduced;
    stage1_t                          s1_q;
    stage2_t                          s2_q;

    assign split = lane_split_e'(lane_mode);

    pdot_lane_split #(.LANES(LANES_MAX), .BLANES(BYTE_LANES)) split_a_i (
        .word (src_a),
        .split(split),
        .sg   (signed_en),
        .opnd (opnd_a)
    );

    pdot_lane_split #(.LANES(LANES_MAX), .BLANES(BYTE_LANES)) split_b_i (
        .word (src_b),
        .split(split),
        .sg   (signed_en),
        .opnd (opnd_b)
    );

    for (genvar i = 0; i < LANES_MAX; i++) begin : g_mul
        pdot_lane_mul mul_i (
            .a(opnd_a[i]),
            .b(opnd_b[i]),
            .p(prod_c[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q.valid <= 1'b0;
        end else begin
            s1_q.valid <= in_valid;
        end
        s1_q.sat  <= sat_en;
        s1_q.acc  <= acc_in;
        s1_q.prod <= prod_c;
    end

    pdot_reduce #(.LANES(LANES_MAX)) reduce_i (
        .prod (s1_q.prod),
        .acc  (s1_q.acc),
        .sat  (s1_q.sat),
        .value(reduced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q.valid <= 1'b0;
        end else begin
            s2_q.valid <= s1_q.valid;
        end
        s2_q.value <= reduced;
    end

    assign out_valid = s2_q.valid;
    assign result    = s2_q.value;

endmodule

// File: rtl/pdot_checker.sv
module pdot_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        signed_en,
    input logic        sat_en,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [31:0] acc_in,
    input logic        out_valid,
    input logic [31:0] result
);

    logic [1:0] clean_cycles;
    logic       hist_ok;

    always_ff @(posedge clk) begin
        if (rst)
            clean_cycles <= 2'd0;
        else if (clean_cycles != 2'd2)
            clean_cycles <= clean_cycles + 2'd1;
    end

    assign hist_ok = (clean_cycles == 2'd2);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid); // R8

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (out_valid == $past(in_valid, 2))); // R6

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 2) && ($past(src_a, 2) == 32'd0 || $past(src_b, 2) == 32'd0))
        |-> (result == $past(acc_in, 2))); // R10

    AST_UNSIGNED_GROWS: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 2) && !$past(signed_en, 2) && $past(sat_en, 2))
        |-> ($signed(result) >= $signed($past(acc_in, 2)))); // R5

    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(result)); // R7

endmodule

bind packed_dot_acc pdot_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .signed_en(signed_en),
    .sat_en   (sat_en),
    .src_a    (src_a),
    .src_b    (src_b),
    .acc_in   (acc_in),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/packed_dot_acc_tb_top.sv
`timescale 1ns/1ps
module packed_dot_acc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        lane_mode = 1'b0;
    logic        signed_en = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] acc_in = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    packed_dot_acc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
        .signed_en(signed_en), .sat_en(sat_en), .src_a(src_a), .src_b(src_b),
        .acc_in(acc_in), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(input logic md, input logic sg, input logic sat,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] acc);
        longint sum = 0;
        longint tot;
        int w = md ? 4 : 8;
        int n = md ? 8 : 4;
        for (int i = 0; i < n; i++) begin
            longint ea = longint'((a >> (w * i)) & ((32'd1 << w) - 1));
            longint eb = longint'((b >> (w * i)) & ((32'd1 << w) - 1));
            if (sg && ea >= (longint'(1) << (w - 1))) ea = ea - (longint'(1) << w);
            if (sg && eb >= (longint'(1) << (w - 1))) eb = eb - (longint'(1) << w);
            sum = sum + ea * eb;
        end
        tot = longint'($signed(acc)) + sum;
        if (sat) begin
            if (tot > 64'sd2147483647) tot = 64'sd2147483647;
            if (tot < -64'sd2147483648) tot = -64'sd2147483648;
        end
        return tot[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic md, input logic sg, input logic sat,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
        in_valid = v; lane_mode = md; signed_en = sg; sat_en = sat;
        src_a = a; src_b = b; acc_in = acc;
    endtask

    task automatic one_op(input string req, input logic md, input logic sg, input logic sat,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
        @(negedge clk);
        drive(1'b1, md, sg, sat, a, b, acc);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
        check({req, " early valid"}, {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check(req, result, model(md, sg, sat, a, b, acc));
        @(negedge clk);
        check({req, " valid drop"}, {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R8 reset state", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_byte_mode();
        one_op("R1 dot4 unsigned", 1'b0, 1'b0, 1'b0, 32'h04030201, 32'h08070605, 32'd100);
        one_op("R1 dot4 lane order", 1'b0, 1'b0, 1'b0, 32'h00000010, 32'h10000000, 32'd7);
        one_op("R3 dot4 signed", 1'b0, 1'b1, 1'b0, 32'hFF02FD04, 32'h05FA0709, 32'hFFFFFF00);
        one_op("R3 dot4 unsigned same bits", 1'b0, 1'b0, 1'b0, 32'hFF02FD04, 32'h05FA0709, 32'd0);
    endtask

    task automatic t_nibble_mode();
        one_op("R2 dot8 unsigned", 1'b1, 1'b0, 1'b0, 32'h87654321, 32'h12345678, 32'd5);
        one_op("R2 dot8 signed", 1'b1, 1'b1, 1'b0, 32'h8F7A0C31, 32'hF1E2D3C4, 32'd0);
        one_op("R2 dot8 top lane", 1'b1, 1'b0, 1'b0, 32'h30000000, 32'h50000000, 32'd0);
    endtask

    task automatic t_extremes();
        one_op("R9 dot4 all ones", 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0);
        one_op("R9 dot4 most negative", 1'b0, 1'b1, 1'b0, 32'h80808080, 32'h80808080, 32'd0);
        one_op("R9 dot8 most negative", 1'b1, 1'b1, 1'b0, 32'h88888888, 32'h88888888, 32'd0);
        one_op("R10 zero source", 1'b1, 1'b1, 1'b1, 32'h0, 32'hDEADBEEF, 32'h12345678);
    endtask

    task automatic t_wrap_sat();
        one_op("R4 wrap high", 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFF0);
        one_op("R5 clamp high", 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFF0);
        one_op("R4 wrap low", 1'b0, 1'b1, 1'b0, 32'h7F7F7F7F, 32'h80808080, 32'h80000010);
        one_op("R5 clamp low", 1'b0, 1'b1, 1'b1, 32'h7F7F7F7F, 32'h80808080, 32'h80000010);
        one_op("R5 in range", 1'b1, 1'b1, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h00001000);
    endtask

    task automatic t_stream();
        logic [31:0] exp_v [8];
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R7 stream valid", {31'b0, out_valid}, 32'd1);
                check("R7 stream result", result, exp_v[k-2]);
            end
            if (k < 8) begin
                logic md  = k[0];
                logic sg  = k[1];
                logic sat = k[2];
                logic [31:0] a = 32'h9E3779B9 * (k + 1);
                logic [31:0] b = 32'h7F4A7C15 ^ (32'h01010101 * k);
                logic [31:0] c = 32'h7FFF0000 + 32'h11111111 * k;
                exp_v[k] = model(md, sg, sat, a, b, c);
                drive(1'b1, md, sg, sat, a, b, c);
            end else begin
                drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
            end
        end
        @(negedge clk);
        check("R6 stream end", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_reset_flight();
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h01010101, 32'h01010101, 32'd0);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 flight dropped", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R8 flight still low", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_byte_mode();
        t_nibble_mode();
        t_extremes();
        t_wrap_sat();
        t_stream();
        t_reset_flight();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule